// File: doc/BRIEF.md
# Four-Stage Fetch Sequencer with Optional Branch Delay Slot

This block is the control-flow front end of an in-order pipeline with four stages: fetch, decode, execute and write-back. It drives the address of a synchronous instruction memory and forwards a stream of valid flag, instruction word and PC through decode into execute. It then carries each executed entry one more stage into write-back. Branches are resolved by the consumer while they sit in execute, which returns a taken flag and a target address.

A mode input picks how a taken branch is handled. In delay-slot mode the instruction that followed the branch, sitting in decode, still runs, and only the fetch-stage instruction is dropped. This leaves one bubble. In squash mode both younger instructions are dropped, which leaves two bubbles. Dropped entries stay in the pipeline with their valid bit cleared, so they never reach write-back as valid. For PC-relative operands the block also presents a base value for the executing instruction that points two instructions past its own address.

Top module: `ifetch_front`

## Requirements
- R1: While reset is held, `exValid` and `wbValid` are 0 and `imemAddr` equals `RESET_VEC`. After release, the first valid execute entry appears in the third cycle (after two rising edges) with `exPc` = `RESET_VEC`.
- R2: Without a taken branch, `imemAddr` advances by `INSTR_BYTES` (4) every cycle. Execute receives consecutive addresses with no empty cycle between them.
- R3: In the cycle after a valid execute entry is reported taken, `imemAddr` equals the target given with it. Fetch then continues upward from the target in 4-byte steps.
- R4: With `delaySlotMode` = 1, the execute stage around a taken branch at address B with target T shows B, then B+4 (valid), then one invalid cycle, then T.
- R5: With `delaySlotMode` = 0, the execute stage around a taken branch at B with target T shows B, then two invalid cycles, then T. B+4 does not execute.
- R6: In delay-slot mode, a taken branch that itself sits in the delay slot sets the next redirect. The first target is fetched once in the following cycle but never executes. Execute shows B1, B1+4, two invalid cycles, then the second target.
- R7: `exPcRel` equals `exPc` + 2*`INSTR_BYTES` (8 with 4-byte instructions).
- R8: Write-back shows, one cycle later, the valid flag and PC that execute held. A discarded entry never appears with `wbValid` = 1.
- R9: `exInstr` is the memory word stored at `exPc`.
- R10: `exBrTaken` has no effect while `exValid` is 0. Fetch stays sequential and the stream in execute is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| delaySlotMode | input | 1 | 1 = one delay slot, 0 = squash both younger instructions |
| imemAddr | output | ADDR_W | Byte address sent to the instruction memory |
| imemRdata | input | INSTR_W | Memory word for the address sent one cycle earlier |
| exValid | output | 1 | Execute entry is valid |
| exInstr | output | INSTR_W | Instruction word in execute |
| exPc | output | ADDR_W | Address of the instruction in execute |
| exPcRel | output | ADDR_W | PC-relative base seen by the executing instruction |
| exBrTaken | input | 1 | Execute reports its branch as taken |
| exBrTarget | input | ADDR_W | Branch target, used with exBrTaken |
| wbValid | output | 1 | Write-back entry is valid and may commit |
| wbInstr | output | INSTR_W | Instruction word in write-back |
| wbPc | output | ADDR_W | Address of the instruction in write-back |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and words, 4-byte instructions, a lookahead of two instructions and a reset vector of 0x100. With these values a branch placed two words after the reset vector reaches execute early enough to see the full fill, the delay slot and the refill within a dozen cycles. The bench covers both modes, a taken branch sitting in the delay slot, and a taken flag raised during a bubble. A memory image that is a fixed function of the address lets every executed word be tied back to its PC.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;
  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic redirect;    // load the fetch PC with the branch target
    logic killFetch;   // the word now being fetched enters decode as invalid
    logic killDecode;  // the decode entry enters execute as invalid
  } fseqStrobe_t;
endpackage

// File: rtl/fseq_ctrl.sv
`timescale 1ns/1ps
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic        delaySlotMode,
  input  logic        exValid,
  input  logic        exBrTaken,
  output fseqStrobe_t strobe
);
  logic brFire;

  // A taken flag only counts when a real instruction sits in execute.
  assign brFire = exValid & exBrTaken;

  always_comb begin
    strobe            = '0;
    strobe.redirect   = brFire;
    strobe.killFetch  = brFire;
    // With a delay slot the decode entry survives; otherwise it is dropped too.
    strobe.killDecode = brFire & ~delaySlotMode;
  end
endmodule

// File: rtl/fseq_datapath.sv
`timescale 1ns/1ps
module fseq_datapath
  import fseq_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                INSTR_W     = 32,
  parameter int                INSTR_BYTES = 4,
  parameter int                AHEAD       = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC   = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  fseqStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  brTarget,
  input  logic [INSTR_W-1:0] imemRdata,
  output logic [ADDR_W-1:0]  imemAddr,
  output logic               exValid,
  output logic [INSTR_W-1:0] exInstr,
  output logic [ADDR_W-1:0]  exPc,
  output logic [ADDR_W-1:0]  exPcRel,
  output logic               wbValid,
  output logic [INSTR_W-1:0] wbInstr,
  output logic [ADDR_W-1:0]  wbPc
);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(INSTR_BYTES);
  localparam logic [ADDR_W-1:0] REL_OFS = ADDR_W'(AHEAD * INSTR_BYTES);

  logic [ADDR_W-1:0]  fetchPc;
  logic               decValid;
  logic [ADDR_W-1:0]  decPc;
  logic               exValidQ;
  logic [ADDR_W-1:0]  exPcQ;
  logic [INSTR_W-1:0] exInstrQ;
  logic               wbValidQ;
  logic [ADDR_W-1:0]  wbPcQ;
  logic [INSTR_W-1:0] wbInstrQ;

  // Fetch: the address goes out now and the word returns during decode.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPc <= RESET_VEC;
    end else if (strobe.redirect) begin
      fetchPc <= brTarget;
    end else begin
      fetchPc <= fetchPc + STEP;
    end
  end

  // Decode: the instruction word is the memory output in this cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid <= 1'b0;
      decPc    <= RESET_VEC;
    end else begin
      decValid <= ~strobe.killFetch;
      decPc    <= fetchPc;
    end
  end

  // Execute: the memory word is captured with the PC it belongs to.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      exValidQ <= 1'b0;
      exPcQ    <= RESET_VEC;
      exInstrQ <= '0;
    end else begin
      exValidQ <= decValid & ~strobe.killDecode;
      exPcQ    <= decPc;
      exInstrQ <= imemRdata;
    end
  end

  // Write-back: invalid entries pass through but never commit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValidQ <= 1'b0;
      wbPcQ    <= RESET_VEC;
      wbInstrQ <= '0;
    end else begin
      wbValidQ <= exValidQ;
      wbPcQ    <= exPcQ;
      wbInstrQ <= exInstrQ;
    end
  end

  // PC-relative base: the visible PC runs AHEAD instructions in front.
  generate
    if (AHEAD == 0) begin : g_relSame
      assign exPcRel = exPcQ;
    end else begin : g_relAhead
      assign exPcRel = exPcQ + REL_OFS;
    end
  endgenerate

  assign imemAddr = fetchPc;
  assign exValid  = exValidQ;
  assign exPc     = exPcQ;
  assign exInstr  = exInstrQ;
  assign wbValid  = wbValidQ;
  assign wbPc     = wbPcQ;
  assign wbInstr  = wbInstrQ;
endmodule

// File: rtl/ifetch_front.sv
`timescale 1ns/1ps
module ifetch_front
  import fseq_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                INSTR_W     = 32,
  parameter int                INSTR_BYTES = 4,
  parameter int                AHEAD       = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC   = ADDR_W'(32'h100)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               delaySlotMode,
  output logic [ADDR_W-1:0]  imemAddr,
  input  logic [INSTR_W-1:0] imemRdata,
  output logic               exValid,
  output logic [INSTR_W-1:0] exInstr,
  output logic [ADDR_W-1:0]  exPc,
  output logic [ADDR_W-1:0]  exPcRel,
  input  logic               exBrTaken,
  input  logic [ADDR_W-1:0]  exBrTarget,
  output logic               wbValid,
  output logic [INSTR_W-1:0] wbInstr,
  output logic [ADDR_W-1:0]  wbPc
);
  fseqStrobe_t strobe;

  fseq_ctrl ctrl_i (
    .delaySlotMode (delaySlotMode),
    .exValid       (exValid),
    .exBrTaken     (exBrTaken),
    .strobe        (strobe)
  );

  fseq_datapath #(
    .ADDR_W      (ADDR_W),
    .INSTR_W     (INSTR_W),
    .INSTR_BYTES (INSTR_BYTES),
    .AHEAD       (AHEAD),
    .RESET_VEC   (RESET_VEC)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .brTarget  (exBrTarget),
    .imemRdata (imemRdata),
    .imemAddr  (imemAddr),
    .exValid   (exValid),
    .exInstr   (exInstr),
    .exPc      (exPc),
    .exPcRel   (exPcRel),
    .wbValid   (wbValid),
    .wbInstr   (wbInstr),
    .wbPc      (wbPc)
  );
endmodule

// File: rtl/fseq_checker.sv
`timescale 1ns/1ps
module fseq_checker #(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              delaySlotMode,
  input logic [ADDR_W-1:0] imemAddr,
  input logic              exValid,
  input logic [ADDR_W-1:0] exPc,
  input logic              exBrTaken,
  input logic [ADDR_W-1:0] exBrTarget,
  input logic              wbValid,
  input logic [ADDR_W-1:0] wbPc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  AST_REDIRECT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exBrTaken) |=> (imemAddr == $past(exBrTarget))); // R3

  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    !exBrTaken |=> (imemAddr == $past(imemAddr) + STEP)); // R2

  AST_IDLE_FLAG_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!exValid && exBrTaken) |=> (imemAddr == $past(imemAddr) + STEP)); // R10

  AST_SLOT_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exBrTaken && delaySlotMode && !$past(exValid && exBrTaken))
      |=> (exValid && exPc == $past(exPc) + STEP)); // R4

  AST_ONE_HOLE: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exBrTaken) |=> ##1 !exValid); // R4

  AST_SQUASH_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exBrTaken && !delaySlotMode) |=> !exValid); // R5

  AST_NO_HOLE_STREAM: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && !exBrTaken && $past(exValid && !exBrTaken))
      |=> (exValid && exPc == $past(exPc) + STEP)); // R2

  AST_WB_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (wbValid == $past(exValid))); // R8

  AST_WB_PC: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbPc == $past(exPc))); // R8
endmodule

bind ifetch_front fseq_checker #(
  .ADDR_W      (ADDR_W),
  .INSTR_BYTES (INSTR_BYTES)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .delaySlotMode (delaySlotMode),
  .imemAddr      (imemAddr),
  .exValid       (exValid),
  .exPc          (exPc),
  .exBrTaken     (exBrTaken),
  .exBrTarget    (exBrTarget),
  .wbValid       (wbValid),
  .wbPc          (wbPc)
);

// File: tb/ifetch_front_tb_top.sv
`timescale 1ns/1ps
module ifetch_front_tb_top;
  localparam logic [31:0] RV = 32'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        delaySlotMode = 1'b1;
  logic [31:0] imemAddr;
  logic [31:0] imemRdata = '0;
  logic        exValid;
  logic [31:0] exInstr;
  logic [31:0] exPc;
  logic [31:0] exPcRel;
  logic        exBrTaken;
  logic [31:0] exBrTarget;
  logic        wbValid;
  logic [31:0] wbInstr;
  logic [31:0] wbPc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Branch table driven back into the block, plus a stray flag for R10.
  logic        br1En = 0, br2En = 0, ghostOn = 0;
  logic [31:0] br1Pc = 0, br1Tgt = 0, br2Pc = 0, br2Tgt = 0, ghostTgt = 0;

  // Trace of one run, one entry per cycle after reset release.
  logic        tV   [64];
  logic [31:0] tPc  [64];
  logic [31:0] tIns [64];
  logic [31:0] tRel [64];
  logic [31:0] tAddr[64];
  logic        tWbV [64];
  logic [31:0] tWbPc[64];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  always_ff @(posedge clk) imemRdata <= memWord(imemAddr);

  always_comb begin
    exBrTaken  = 1'b0;
    exBrTarget = '0;
    if (ghostOn) begin
      exBrTaken  = 1'b1;
      exBrTarget = ghostTgt;
    end else if (exValid && br1En && exPc == br1Pc) begin
      exBrTaken  = 1'b1;
      exBrTarget = br1Tgt;
    end else if (exValid && br2En && exPc == br2Pc) begin
      exBrTaken  = 1'b1;
      exBrTarget = br2Tgt;
    end
  end

  ifetch_front dut_i (
    .clk           (clk),
    .rstN          (rstN),
    .delaySlotMode (delaySlotMode),
    .imemAddr      (imemAddr),
    .imemRdata     (imemRdata),
    .exValid       (exValid),
    .exInstr       (exInstr),
    .exPc          (exPc),
    .exPcRel       (exPcRel),
    .exBrTaken     (exBrTaken),
    .exBrTarget    (exBrTarget),
    .wbValid       (wbValid),
    .wbInstr       (wbInstr),
    .wbPc          (wbPc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    rstN = 1'b0;
    delaySlotMode = mode;
    ghostOn = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(exValid == 1'b0, "R1 exValid in reset", 32'(exValid), 32'h0);
    chk(wbValid == 1'b0, "R1 wbValid in reset", 32'(wbValid), 32'h0);
    chk(imemAddr == RV, "R1 imemAddr in reset", imemAddr, RV);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic capture(input int n, input int ghostAt, input logic [31:0] gTgt);
    ghostTgt = gTgt;
    for (int k = 0; k < n; k++) begin
      ghostOn = (k == ghostAt);
      #1;
      tV[k]    = exValid;
      tPc[k]   = exPc;
      tIns[k]  = exInstr;
      tRel[k]  = exPcRel;
      tAddr[k] = imemAddr;
      tWbV[k]  = wbValid;
      tWbPc[k] = wbPc;
      @(negedge clk);
    end
    ghostOn = 1'b0;
  endtask

  task automatic expE(input int k, input logic v, input logic [31:0] pc, input string req);
    chk(tV[k] == v, req, 32'(tV[k]), 32'(v));
    if (v) chk(tPc[k] == pc, req, tPc[k], pc);
  endtask

  task automatic setBranches(input logic e1, input logic [31:0] p1, input logic [31:0] t1,
                             input logic e2, input logic [31:0] p2, input logic [31:0] t2);
    br1En = e1; br1Pc = p1; br1Tgt = t1;
    br2En = e2; br2Pc = p2; br2Tgt = t2;
  endtask

  task automatic testStraight();
    setBranches(0, 0, 0, 0, 0, 0);
    doReset(1'b1);
    capture(20, -1, 0);
    expE(0, 1'b0, 0, "R1 cycle0 empty");
    expE(1, 1'b0, 0, "R1 cycle1 empty");
    expE(2, 1'b1, RV, "R1 first execute");
    for (int k = 2; k < 20; k++) begin
      logic [31:0] pc;
      pc = RV + 32'(4 * (k - 2));
      expE(k, 1'b1, pc, "R2 sequential execute");
      chk(tIns[k] == memWord(pc), "R9 word matches pc", tIns[k], memWord(pc));
      chk(tRel[k] == pc + 32'd8, "R7 pc-relative base", tRel[k], pc + 32'd8);
      chk(tAddr[k] == RV + 32'(4 * k), "R2 fetch address step", tAddr[k], RV + 32'(4 * k));
      if (k >= 3) begin
        chk(tWbV[k] == 1'b1, "R8 wb valid follows", 32'(tWbV[k]), 32'h1);
        chk(tWbPc[k] == tPc[k-1], "R8 wb pc follows", tWbPc[k], tPc[k-1]);
      end
    end
  endtask

  task automatic testSlot();
    setBranches(1, 32'h108, 32'h400, 0, 0, 0);
    doReset(1'b1);
    capture(12, -1, 0);
    expE(4, 1'b1, 32'h108, "R4 branch");
    expE(5, 1'b1, 32'h10C, "R4 delay slot runs");
    expE(6, 1'b0, 0, "R4 single bubble");
    expE(7, 1'b1, 32'h400, "R4 target");
    expE(8, 1'b1, 32'h404, "R3 sequential after target");
    chk(tAddr[5] == 32'h400, "R3 redirect address", tAddr[5], 32'h400);
    chk(tWbV[6] == 1'b1 && tWbPc[6] == 32'h10C, "R8 slot commits", tWbPc[6], 32'h10C);
    chk(tWbV[7] == 1'b0, "R8 bubble not committed", 32'(tWbV[7]), 32'h0);
  endtask

  task automatic testNoSlot();
    setBranches(1, 32'h108, 32'h400, 0, 0, 0);
    doReset(1'b0);
    capture(12, -1, 0);
    expE(4, 1'b1, 32'h108, "R5 branch");
    expE(5, 1'b0, 0, "R5 first bubble");
    expE(6, 1'b0, 0, "R5 second bubble");
    expE(7, 1'b1, 32'h400, "R5 target");
    chk(tAddr[5] == 32'h400, "R3 redirect address", tAddr[5], 32'h400);
    chk(tWbV[6] == 1'b0, "R8 squashed entry not committed", 32'(tWbV[6]), 32'h0);
    chk(tWbV[7] == 1'b0, "R8 squashed entry not committed", 32'(tWbV[7]), 32'h0);
  endtask

  task automatic testNested();
    setBranches(1, 32'h108, 32'h400, 1, 32'h10C, 32'h800);
    doReset(1'b1);
    capture(16, -1, 0);
    expE(4, 1'b1, 32'h108, "R6 first branch");
    expE(5, 1'b1, 32'h10C, "R6 slot branch");
    expE(6, 1'b0, 0, "R6 bubble one");
    expE(7, 1'b0, 0, "R6 bubble two");
    expE(8, 1'b1, 32'h800, "R6 second target");
    expE(9, 1'b1, 32'h804, "R6 after second target");
    chk(tAddr[5] == 32'h400, "R6 first target fetched", tAddr[5], 32'h400);
    chk(tAddr[6] == 32'h800, "R6 second redirect", tAddr[6], 32'h800);
    for (int k = 0; k < 16; k++) begin
      if (tV[k] && tPc[k] == 32'h400)
        chk(1'b0, "R6 first target must not execute", tPc[k], 32'h800);
    end
  endtask

  task automatic testGhost();
    setBranches(1, 32'h108, 32'h400, 0, 0, 0);
    doReset(1'b1);
    capture(16, 6, 32'h900);
    expE(6, 1'b0, 0, "R10 bubble under stray flag");
    chk(tAddr[7] == 32'h408, "R10 fetch stays sequential", tAddr[7], 32'h408);
    expE(7, 1'b1, 32'h400, "R10 target unchanged");
    expE(8, 1'b1, 32'h404, "R10 stream unchanged");
    for (int k = 0; k < 16; k++) begin
      if (tV[k] && tPc[k] == 32'h900)
        chk(1'b0, "R10 stray target executed", tPc[k], 32'h404);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testStraight();
    testSlot();
    testNoSlot();
    testNested();
    testGhost();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule